// File: doc/BRIEF.md
# Single-Channel PWM Generator with End-of-Cycle Buffered Update

This block produces one pulse-width-modulated output from an active period value and an active duty value. Software does not change the running waveform directly. It writes a new value into one shared staging register, and a steering bit in the control register chooses whether that value will replace the period or the duty value. The staged value is applied only when the current PWM cycle finishes, so no period is ever cut short or stretched partway through.

Each time a cycle completes, a sticky end-of-cycle flag is raised. The flag tells software that the staged value has been taken and that a new one may be written. Software can poll the flag or let it raise an interrupt through an enable bit. Reading the status register clears the flag. The counter can run edge-aligned (sawtooth) or center-aligned (triangle), and the output polarity can be chosen. Both of these settings are locked while the channel runs.

Register port (word addresses): 0 control, 1 period, 2 duty, 3 staging, 4 status, 5 interrupt enable. Reads are combinational on `reg_addr`.

Top module: `pwm_buf_chan`

## Requirements
- R1: A value written to the staging register (address 3) does not change the active duty (address 2) or period (address 1) before the current cycle ends. At the end-of-cycle clock edge the staged value is committed, if one is pending.
- R2: Control bit 3 selects the target of the commit: 0 replaces the duty value and 1 replaces the period value. The bit can be written at any time.
- R3: At the clock edge that ends a cycle, the end-of-cycle flag (status address 4, bit 0) becomes 1 and stays 1.
- R4: A read of address 4 returns the flag and clears it at that edge, unless a cycle ends at the same edge.
- R5: `irq` is 1 exactly when the flag is set and interrupt-enable bit 0 at address 5 is 1. The flag can be polled while the enable is 0.
- R6: Control bit 1 (polarity, 1 = active high) and bit 2 (1 = center aligned) take a written value only while the channel is disabled (control bit 0 = 0). Direct writes to the period and duty registers are also taken only while the channel is disabled. The control register resets to 0x2.
- R7: In edge-aligned mode the counter runs 0 to P-1 and wraps, so a cycle lasts max(P,1) clocks.
- R8: In center-aligned mode the counter climbs from 0 to P and falls back, and the cycle ends when it reaches 0 again, so a cycle lasts 2P clocks (1 clock if P = 0).
- R9: The output is at its active level while the counter is below the duty value and at its inactive level otherwise. A disabled channel drives the inactive level.
- R10: If the staging register is written more than once in a cycle, only the last value is committed.
- R11: A duty value of 0 gives a constant inactive output. A duty value of P or more, with a duty value that is not 0, gives a constant active output.
- R12: Enabling the channel starts the counter at 0 and discards any staged value, so the first cycle uses the directly programmed period and duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a read of status clears the flag) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench measures the number of active-level clocks over exactly one cycle for edge-aligned and center-aligned patterns, including duty 0, duty equal to the period, duty above the period and a period of 1. An off-by-one in the wrap or turnaround logic shifts either the cycle length or the active count. The bench also writes the staging register early in a cycle and reads the duty back before and after the boundary. A design that applies the value at once fails the first read, and one that keeps the first of two writes fails the last-write check. Further tests try to change polarity, alignment and the period while the channel runs, and enable the channel with a stale staged value. A design without these locks, or one that commits the stale value, shows a changed register value.

// File: rtl/pwm_buf_chan_pkg.sv
package pwm_buf_chan_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_DUTY   = 3'd2,
    A_STAGE  = 3'd3,
    A_STATUS = 3'd4,
    A_IEN    = 3'd5
  } reg_addr_e;

  localparam int B_EN    = 0;
  localparam int B_POL   = 1;
  localparam int B_ALIGN = 2;
  localparam int B_SEL   = 3;
endpackage

// File: rtl/pwm_buf_chan_regs.sv
module pwm_buf_chan_regs
  import pwm_buf_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          eoc,
  output logic [CW-1:0] reg_rdata,
  output logic          en_q,
  output logic          pol_q,
  output logic          align_q,
  output logic          ie_q,
  output logic          flag_q,
  output logic          start,
  output logic          pend_vld_q,
  output logic [CW-1:0] period_q,
  output logic [CW-1:0] duty_q
);
  logic          sel_q;
  logic [CW-1:0] pend_q;

  logic          en_d, pol_d, align_d, sel_d, ie_d, flag_d, pend_vld_d;
  logic [CW-1:0] period_d, duty_d, pend_d;
  logic          wr_ctrl, wr_per, wr_dut, wr_stg, wr_ien, rd_stat;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == A_CTRL);
    wr_per  = reg_we && (reg_addr == A_PERIOD);
    wr_dut  = reg_we && (reg_addr == A_DUTY);
    wr_stg  = reg_we && (reg_addr == A_STAGE);
    wr_ien  = reg_we && (reg_addr == A_IEN);
    rd_stat = reg_re && (reg_addr == A_STATUS);
    start   = wr_ctrl && reg_wdata[B_EN] && !en_q;
  end

  // next-state logic
  always_comb begin
    en_d       = en_q;
    pol_d      = pol_q;
    align_d    = align_q;
    sel_d      = sel_q;
    ie_d       = ie_q;
    flag_d     = flag_q;
    pend_vld_d = pend_vld_q;
    pend_d     = pend_q;
    period_d   = period_q;
    duty_d     = duty_q;

    if (wr_ctrl) begin
      en_d  = reg_wdata[B_EN];
      sel_d = reg_wdata[B_SEL];
      if (!en_q) begin
        pol_d   = reg_wdata[B_POL];
        align_d = reg_wdata[B_ALIGN];
      end
    end
    if (wr_ien) ie_d = reg_wdata[0];

    if (wr_per && !en_q) period_d = reg_wdata;
    if (wr_dut && !en_q) duty_d   = reg_wdata;

    // commit the staged value at the cycle boundary
    if (eoc && pend_vld_q) begin
      pend_vld_d = 1'b0;
      if (sel_q) period_d = pend_q;
      else       duty_d   = pend_q;
    end
    if (wr_stg) begin
      pend_d     = reg_wdata;
      pend_vld_d = 1'b1;
    end
    if (start) pend_vld_d = 1'b0;

    if (rd_stat) flag_d = 1'b0;
    if (eoc)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      pol_q      <= 1'b1;
      align_q    <= 1'b0;
      sel_q      <= 1'b0;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      period_q   <= '0;
      duty_q     <= '0;
    end else begin
      en_q       <= en_d;
      pol_q      <= pol_d;
      align_q    <= align_d;
      sel_q      <= sel_d;
      ie_q       <= ie_d;
      flag_q     <= flag_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      period_q   <= period_d;
      duty_q     <= duty_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_EN]    = en_q;
        reg_rdata[B_POL]   = pol_q;
        reg_rdata[B_ALIGN] = align_q;
        reg_rdata[B_SEL]   = sel_q;
      end
      A_PERIOD: reg_rdata    = period_q;
      A_DUTY:   reg_rdata    = duty_q;
      A_STAGE:  reg_rdata    = pend_q;
      A_STATUS: reg_rdata[0] = flag_q;
      A_IEN:    reg_rdata[0] = ie_q;
      default:  reg_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/pwm_buf_chan_cnt.sv
module pwm_buf_chan_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          center,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_q,
  output logic          eoc
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          up_q, up_d;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    wrap  = 1'b0;
    if (!center) begin
      if (({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, period}) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
      up_d = 1'b1;
    end else if (up_q) begin
      if (cnt_q >= period) begin
        if (cnt_q <= ONE) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
          up_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        cnt_d = '0;
        up_d  = 1'b1;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    eoc = en && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (start || !en) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/pwm_buf_chan_wave.sv
module pwm_buf_chan_wave #(
  parameter int CW = 16
) (
  input  logic          en,
  input  logic          pol,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  output logic          pwm_out
);
  logic active;

  always_comb begin
    active  = en && (duty != '0) && ((cnt < duty) || (duty >= period));
    pwm_out = pol ? active : !active;
  end
endmodule

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan
  import pwm_buf_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq,
  output logic          pwm_out
);
  logic          en_q, pol_q, align_q, ie_q, flag_q, start, pend_vld_q, eoc;
  logic [CW-1:0] period_q, duty_q, cnt_q;

  pwm_buf_chan_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eoc(eoc),
    .reg_rdata(reg_rdata), .en_q(en_q), .pol_q(pol_q), .align_q(align_q),
    .ie_q(ie_q), .flag_q(flag_q), .start(start), .pend_vld_q(pend_vld_q),
    .period_q(period_q), .duty_q(duty_q)
  );

  pwm_buf_chan_cnt #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start), .center(align_q),
    .period(period_q), .cnt_q(cnt_q), .eoc(eoc)
  );

  pwm_buf_chan_wave #(.CW(CW)) wave_i (
    .en(en_q), .pol(pol_q), .cnt(cnt_q), .period(period_q), .duty(duty_q),
    .pwm_out(pwm_out)
  );

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/pwm_buf_chan_chk.sv
module pwm_buf_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          pol_q,
  input logic          align_q,
  input logic          eoc,
  input logic          flag_q,
  input logic          pend_vld_q,
  input logic          reg_re,
  input logic [2:0]    reg_addr,
  input logic          pwm_out,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] period_q,
  input logic [CW-1:0] duty_q
);
  assert_hold_midcycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !eoc) |=> ($stable(period_q) && $stable(duty_q)));

  assert_flag_on_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> flag_q);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == 3'd4 && !eoc) |=> !flag_q);

  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(pol_q) && $stable(align_q)));

  assert_edge_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !align_q && cnt_q != '0) |-> (cnt_q < period_q));

  assert_center_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && align_q) |-> (cnt_q <= period_q || cnt_q == '0));

  assert_duty_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (pwm_out == !pol_q));

  assert_enable_fresh_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (cnt_q == '0 && !pend_vld_q));
endmodule

bind pwm_buf_chan pwm_buf_chan_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pol_q(pol_q), .align_q(align_q),
  .eoc(eoc), .flag_q(flag_q), .pend_vld_q(pend_vld_q), .reg_re(reg_re),
  .reg_addr(reg_addr), .pwm_out(pwm_out), .cnt_q(cnt_q),
  .period_q(period_q), .duty_q(duty_q)
);

// File: tb/pwm_buf_chan_tb_top.sv
module pwm_buf_chan_tb_top;
  localparam int CW = 16;

  logic          clk, rst_n, reg_we, reg_re, irq, pwm_out;
  logic [2:0]    reg_addr;
  logic [CW-1:0] reg_wdata, reg_rdata, rdv;
  int            n_tests, n_fail;
  logic          done;

  pwm_buf_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {period, duty, pol, center, cycle_len, active_clocks}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {16'd10, 16'd3,  1'b1, 1'b0, 16'd10, 16'd3},
    {16'd10, 16'd0,  1'b1, 1'b0, 16'd10, 16'd0},
    {16'd10, 16'd10, 1'b1, 1'b0, 16'd10, 16'd10},
    {16'd10, 16'd15, 1'b0, 1'b0, 16'd10, 16'd10},
    {16'd8,  16'd3,  1'b1, 1'b1, 16'd16, 16'd5},
    {16'd8,  16'd8,  1'b1, 1'b1, 16'd16, 16'd16},
    {16'd6,  16'd1,  1'b0, 1'b1, 16'd12, 16'd1},
    {16'd1,  16'd1,  1'b1, 1'b0, 16'd1,  16'd1}
  };

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    reg_re = 1'b1; reg_addr = a;
    #1 rdv = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state (R6 reset value, R9 inactive while disabled, R5)
    rd(3'd0); chk("R6 ctrl reset", rdv, 16'h2);
    rd(3'd1); chk("R6 period reset", rdv, 16'd0);
    chk("R9 out idle", {15'd0, pwm_out}, 16'd0);
    chk("R5 irq reset", {15'd0, irq}, 16'd0);

    // vector table: one full cycle per pattern (R7 R8 R9 R11 R3)
    for (int v = 0; v < NV; v++) begin
      logic [15:0] p, d, len, act, cnt;
      logic        pl, cn;
      {p, d, pl, cn, len, act} = VEC[v];
      wr(3'd0, 16'h0);
      rd(3'd4);
      wr(3'd1, p);
      wr(3'd2, d);
      wr(3'd0, {12'd0, 1'b0, cn, pl, 1'b1});
      cnt = '0;
      for (int i = 0; i < int'(len); i++) begin
        if (pwm_out == pl) cnt++;
        @(negedge clk);
      end
      chk(cn ? "R8 R9 R11 center active count" : "R7 R9 R11 edge active count", cnt, act);
      rd(3'd4); chk("R3 flag after cycle", rdv, 16'd1);
    end

    // buffered duty update, P=10 D=3 edge aligned
    wr(3'd0, 16'h0); rd(3'd4);
    wr(3'd1, 16'd10); wr(3'd2, 16'd3);
    wr(3'd0, 16'h3);
    wr(3'd3, 16'd7);
    rd(3'd2); chk("R1 duty unchanged mid-cycle", rdv, 16'd3);
    idle(10);
    rd(3'd2); chk("R1 R2 duty committed", rdv, 16'd7);
    chk("R5 irq gated off", {15'd0, irq}, 16'd0);
    rd(3'd4); chk("R3 R5 flag pollable", rdv, 16'd1);
    rd(3'd4); chk("R4 read cleared flag", rdv, 16'd0);

    // two staged writes in one cycle
    wr(3'd3, 16'd5); wr(3'd3, 16'd8);
    idle(10);
    rd(3'd2); chk("R10 last write wins", rdv, 16'd8);

    // steer to period
    wr(3'd0, 16'hB);
    wr(3'd3, 16'd6);
    idle(10);
    rd(3'd1); chk("R2 period committed", rdv, 16'd6);
    rd(3'd2); chk("R2 duty untouched", rdv, 16'd8);

    // locked settings while running
    wr(3'd0, 16'hD);
    rd(3'd0); chk("R6 pol/align locked", rdv, 16'hB);
    wr(3'd1, 16'd3);
    rd(3'd1); chk("R6 period write ignored", rdv, 16'd6);

    // interrupt
    wr(3'd5, 16'd1);
    idle(8);
    chk("R5 irq raised", {15'd0, irq}, 16'd1);
    wr(3'd0, 16'hA);
    rd(3'd4); chk("R3 flag set", rdv, 16'd1);
    chk("R4 R5 irq cleared by read", {15'd0, irq}, 16'd0);

    // enable drops stale staged value
    wr(3'd1, 16'd4); wr(3'd2, 16'd2);
    wr(3'd0, 16'h2);
    wr(3'd3, 16'd1);
    wr(3'd0, 16'h3);
    begin
      logic [15:0] hc;
      hc = '0;
      for (int i = 0; i < 4; i++) begin
        if (pwm_out) hc++;
        @(negedge clk);
      end
      chk("R12 first cycle uses programmed duty", hc, 16'd2);
    end
    idle(4);
    rd(3'd2); chk("R12 staged value discarded", rdv, 16'd2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule